// File: doc/BRIEF.md
# Centred-Trigger Four-Channel Capture Buffer

The block records a 32-bit word holding four 8-bit channels into a 1024-word circular memory, taking one word every fourth clock. A start pulse begins a recording run. The block first writes a fixed pre-trigger quota of words. It then watches channel 0 for an arm-then-trigger event against two 8-bit thresholds. After the trigger it writes a fixed post-trigger quota and stops writing.

When recording ends, the block presents a read start pointer. This pointer places the trigger word exactly in the middle of a 640-word window. A strobe-driven read port then walks the window through the circular memory, wrapping at the top address, and raises a done flag once the whole window has been consumed.

Top module: `mid_trigger_capture`

## Requirements
- R1: While recording, exactly one word is written every 4 clocks. Counting from the clock edge that samples `start_i` as edge 0, the words present at edges 4, 8, 12, … are written to addresses 0, 1, 2, … in that order. Values on the sample bus at any other edge have no effect.
- R2: The memory holds 1024 words. The write address wraps from 1023 back to 0, and the read address also wraps.
- R3: No arming or triggering takes place until 320 words of the current run have been written. Channel 0 values seen during that period, however low or high, do not count toward a trigger.
- R4: Only bits [7:2] of `arm_lvl_i` and `trig_lvl_i` take part in the comparisons. Bits [1:0] are treated as zero.
- R5: The qualifier becomes armed on a written word whose channel 0 (bits [7:0]) is strictly below the arm level. A value equal to the arm level does not arm. Channels 1 to 3 (bits [31:8]) never affect arming or triggering.
- R6: The trigger word is the first written word after arming whose channel 0 is at or above the trigger level. The arming and triggering word are always distinct words, and the armed state never carries over from a previous run.
- R7: After the trigger word, exactly 320 further words are written. Writing then stops, and the memory is not modified again until the next start.
- R8: `start_ptr_o` equals the trigger word's address minus 320, modulo 1024, from the end of recording until the next trigger.
- R9: During readout, `rd_data_o` shows the word at the current read address, which begins at `start_ptr_o`. Each `rd_strobe_i` advances the address by one, with wrap. After 640 strobes `done_o` rises and the address stops moving.
- R10: `rd_strobe_i` has no effect before recording ends or after `done_o` is high. A `start_i` pulse at any time abandons the current run and begins a new one, and `done_o` stays low until the new window has been read.
- R11: After reset, `done_o` is 0 and `start_ptr_o` is 0, and the block waits idle for `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 32 | Four 8-bit channels, channel k in bits [8k+7:8k] |
| arm_lvl_i | input | 8 | Arm threshold for channel 0 |
| trig_lvl_i | input | 8 | Trigger threshold for channel 0 |
| start_i | input | 1 | One-cycle pulse that starts a recording run |
| rd_strobe_i | input | 1 | Advance the read address by one word |
| rd_data_o | output | 32 | Word at the current read address |
| done_o | output | 1 | Whole window has been read out |
| start_ptr_o | output | 10 | First address of the centred window |

## Verification
The bench drives strong junk on the sample bus between decimation points. A decimator that slipped phase or sampled every clock would therefore store wrong words in the window. One directed run swings channel 0 fully during the pre-trigger quota, then holds it high, then offers values exactly at both masked thresholds. A design that armed early, compared inclusively at the arm level, or used the raw threshold low bits would trigger on the wrong word and shift the start pointer. A late-trigger run forces both the write and read addresses to wrap, catching a subtraction or wrap that is off by a word. Other checks cover strobes issued during recording, a restart in the middle of a run, and random sample traffic during readout, which expose read movement outside readout and writes continuing after the post-trigger quota.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WATCH,
    ST_POST,
    ST_READ
  } cap_state_e;
endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/cap_tick.sv
module cap_tick #(
  parameter int DECIM = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int DIVW = (DECIM > 2) ? $clog2(DECIM) : 1;
  localparam logic [DIVW-1:0] LAST = DIVW'(DECIM - 1);

  logic [DIVW-1:0] div_q, div_d;

  assign tick_o = run_i && (div_q == LAST);

  always_comb begin
    div_d = div_q;
    if (clr_i || !run_i) div_d = '0;
    else if (tick_o)     div_d = '0;
    else                 div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R1
  tick_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_i |=> !tick_o);
endmodule

// File: rtl/cap_qual.sv
module cap_qual #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [CW-1:0] level_i,
  input  logic [CW-1:0] arm_lvl_i,
  input  logic [CW-1:0] trig_lvl_i,
  output logic          fire_o
);
  localparam logic [CW-1:0] LOW_MASK = {{(CW-2){1'b1}}, 2'b00};

  logic          armed_q, armed_d;
  logic [CW-1:0] arm_m, trig_m;

  assign arm_m  = arm_lvl_i & LOW_MASK;
  assign trig_m = trig_lvl_i & LOW_MASK;
  assign fire_o = en_i && tick_i && armed_q && (level_i >= trig_m);

  always_comb begin
    armed_d = armed_q;
    if (!en_i)                             armed_d = 1'b0;
    else if (tick_i && (level_i < arm_m))  armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  // R4
  fire_level_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fire_o |-> (level_i[CW-1:2] >= trig_lvl_i[CW-1:2]));
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mid_trigger_capture.sv
module mid_trigger_capture
  import cap_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int PRE   = 320,
  parameter int POST  = 320,
  parameter int DECIM = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = NUM_CH * CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   sample_i,
  input  logic [CH_W-1:0] arm_lvl_i,
  input  logic [CH_W-1:0] trig_lvl_i,
  input  logic            start_i,
  input  logic            rd_strobe_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            done_o,
  output logic [AW-1:0]   start_ptr_o
);
  localparam int WIN  = PRE + POST;
  localparam int CNTW = $clog2(WIN + 1);
  localparam logic [AW-1:0]   PRE_A   = AW'(PRE % DEPTH);
  localparam logic [AW-1:0]   WIN_A   = AW'(WIN % DEPTH);
  localparam logic [AW-1:0]   POST1_A = AW'((POST + 1) % DEPTH);
  localparam logic [CNTW-1:0] PRE_L   = CNTW'(PRE - 1);
  localparam logic [CNTW-1:0] POST_L  = CNTW'(POST - 1);
  localparam logic [CNTW-1:0] WIN_C   = CNTW'(WIN);

  logic            rst_ni;
  cap_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [AW-1:0]   wptr_q, wptr_d;
  logic [AW-1:0]   trig_addr_q, trig_addr_d;
  logic [AW-1:0]   start_ptr_q, start_ptr_d;
  logic [AW-1:0]   rd_addr_q, rd_addr_d;
  logic            run, tick, smp_tick, fire, rd_step;

  cap_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_no(rst_ni));

  assign run = (state_q == ST_FILL) || (state_q == ST_WATCH) || (state_q == ST_POST);

  cap_tick #(.DECIM(DECIM)) tick_i (
    .clk(clk), .rst_ni(rst_ni), .clr_i(start_i), .run_i(run), .tick_o(tick));

  assign smp_tick = tick && !start_i;

  cap_qual #(.CW(CH_W)) qual_i (
    .clk(clk), .rst_ni(rst_ni),
    .en_i(state_q == ST_WATCH), .tick_i(smp_tick),
    .level_i(sample_i[CH_W-1:0]), .arm_lvl_i(arm_lvl_i), .trig_lvl_i(trig_lvl_i),
    .fire_o(fire));

  cap_mem #(.DEPTH(DEPTH), .DW(DW)) mem_i (
    .clk(clk), .we_i(smp_tick), .waddr_i(wptr_q), .wdata_i(sample_i),
    .raddr_i(rd_addr_q), .rdata_o(rd_data_o));

  assign rd_step = (state_q == ST_READ) && rd_strobe_i && (cnt_q != WIN_C) && !start_i;

  // control sequence
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      state_d = ST_FILL;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_FILL: if (tick) begin
          if (cnt_q == PRE_L) begin state_d = ST_WATCH; cnt_d = '0; end
          else cnt_d = cnt_q + 1'b1;
        end
        ST_WATCH: if (fire) begin state_d = ST_POST; cnt_d = '0; end
        ST_POST: if (tick) begin
          if (cnt_q == POST_L) begin state_d = ST_READ; cnt_d = '0; end
          else cnt_d = cnt_q + 1'b1;
        end
        ST_READ: if (rd_step) cnt_d = cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  // pointer arithmetic
  always_comb begin
    wptr_d      = wptr_q;
    trig_addr_d = trig_addr_q;
    start_ptr_d = start_ptr_q;
    rd_addr_d   = rd_addr_q;
    if (start_i)       wptr_d = '0;
    else if (smp_tick) wptr_d = wptr_q + 1'b1;
    if (fire) begin
      trig_addr_d = wptr_q;
      start_ptr_d = wptr_q - PRE_A;
      rd_addr_d   = wptr_q - PRE_A;
    end else if (rd_step) begin
      rd_addr_d = rd_addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      wptr_q      <= '0;
      trig_addr_q <= '0;
      start_ptr_q <= '0;
      rd_addr_q   <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      wptr_q      <= wptr_d;
      trig_addr_q <= trig_addr_d;
      start_ptr_q <= start_ptr_d;
      rd_addr_q   <= rd_addr_d;
    end
  end

  assign done_o      = (state_q == ST_READ) && (cnt_q == WIN_C);
  assign start_ptr_o = start_ptr_q;

  // R3
  fire_phase_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fire |-> (state_q == ST_WATCH));

  // R7
  post_len_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_READ && $past(state_q) == ST_POST) |-> (wptr_q == trig_addr_q + POST1_A));

  // R8
  start_ptr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_READ) |-> (start_ptr_q + PRE_A == trig_addr_q));

  // R9
  done_addr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> (rd_addr_q == start_ptr_q + WIN_A));

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != ST_READ && state_q != ST_WATCH) |=> $stable(rd_addr_q));
endmodule

// File: tb/mid_trigger_capture_tb_top.sv
`timescale 1ns/1ps
module mid_trigger_capture_tb_top;
  localparam int DEPTH = 1024;
  localparam int PRE   = 320;
  localparam int POST  = 320;
  localparam int WIN   = PRE + POST;
  localparam int MAXN  = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] sample_i;
  logic [7:0]  arm_lvl_i, trig_lvl_i;
  logic        start_i, rd_strobe_i;
  logic [31:0] rd_data_o;
  logic        done_o;
  logic [9:0]  start_ptr_o;

  always #2.5 clk = ~clk;

  mid_trigger_capture dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
    .arm_lvl_i(arm_lvl_i), .trig_lvl_i(trig_lvl_i),
    .start_i(start_i), .rd_strobe_i(rd_strobe_i),
    .rd_data_o(rd_data_o), .done_o(done_o), .start_ptr_o(start_ptr_o));

  int vecs  = 0;
  int fails = 0;
  int cyc   = 0;
  logic [31:0] smp [MAXN];

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc >= 150000);
    fails++;
    $display("FAIL R9 watchdog expired: cycles=%0d expected<%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // channel 0 value for written word n under each stimulus pattern
  function automatic logic [7:0] ch0_of(input int mode, input int n);
    case (mode)
      1: begin
        if (n <= PRE)      return (n % 2) ? 8'h00 : 8'hFF;
        else if (n <= 400) return 8'hC0;
        else if (n == 401) return 8'h70;
        else if (n == 402) return 8'h6F;
        else if (n == 403) return 8'h8F;
        else if (n == 404) return 8'h90;
        else               return 8'h55;
      end
      2: begin
        if (n < 1100)       return 8'h80;
        else if (n == 1100) return 8'h10;
        else                return 8'hF0;
      end
      default: return 8'($urandom);
    endcase
  endfunction

  // an aborted run: start, then junk for a while, never read
  task automatic abort_run(input int cycles);
    @(negedge clk); start_i = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk); start_i = 1'b0;
      sample_i = $urandom; rd_strobe_i = 1'($urandom);
    end
  endtask

  task automatic run_capture(input int mode, input logic [7:0] arml, input logic [7:0] trigl,
                             input int exp_start, input string tag);
    int m, n, nt, exp_sp;
    bit armed, fin;
    logic [7:0] armm, trigm, c;
    logic [31:0] w;
    armm = arml & 8'hFC; trigm = trigl & 8'hFC;
    arm_lvl_i = arml; trig_lvl_i = trigl;
    @(negedge clk); start_i = 1'b1; rd_strobe_i = 1'b0;
    @(posedge clk);
    m = 0; n = 0; nt = 0; armed = 0; fin = 0;
    while (!fin) begin
      @(negedge clk);
      start_i = 1'b0;
      m++;
      rd_strobe_i = 1'($urandom);
      if (m % 4 == 0) begin
        n = m / 4;
        c = ch0_of(mode, n);
        w = {24'($urandom), c};
        if (mode == 1 && n > PRE && n <= 400) w[15:8] = 8'h00;
        sample_i = w;
        smp[n] = w;
        if (nt == 0 && n > PRE) begin
          if (armed && c >= trigm) nt = n;
          else if (c < armm)       armed = 1;
        end
        if (nt != 0 && n == nt + POST) fin = 1;
        if (n >= MAXN - 1) begin
          fin = 1;
          chk("R6 trigger not found", 32'(n), 32'(MAXN - 1 - 1));
        end
      end else begin
        sample_i = {24'($urandom), (m % 2) ? 8'h00 : 8'hFF};
      end
      @(posedge clk);
    end
    if (nt == 0) return;
    @(negedge clk);
    rd_strobe_i = 1'b0;
    sample_i = $urandom;
    exp_sp = (((nt - 1 - PRE) % DEPTH) + DEPTH) % DEPTH;
    chk({"R10 done low before readout ", tag}, 32'(done_o), 32'd0);
    chk({"R8 start pointer ", tag}, 32'(start_ptr_o), 32'(exp_sp));
    if (exp_start >= 0)
      chk({"R3 R4 R5 R6 R2 directed start pointer ", tag}, 32'(start_ptr_o), 32'(exp_start));
    for (int i = 0; i < WIN; i++) begin
      chk({"R1 R9 R7 window word ", tag}, rd_data_o, smp[nt - PRE + i]);
      if (i == PRE) chk({"R6 trigger word centred ", tag}, rd_data_o, smp[nt]);
      rd_strobe_i = 1'b1;
      sample_i = $urandom;
      @(posedge clk);
      @(negedge clk);
    end
    rd_strobe_i = 1'b0;
    chk({"R9 done after window ", tag}, 32'(done_o), 32'd1);
    for (int k = 0; k < 3; k++) begin
      rd_strobe_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk({"R10 strobe after done ", tag}, rd_data_o, smp[nt + POST]);
      chk({"R10 done held ", tag}, 32'(done_o), 32'd1);
    end
    rd_strobe_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; start_i = 1'b0; rd_strobe_i = 1'b0;
    sample_i = '0; arm_lvl_i = 8'h70; trig_lvl_i = 8'h90;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R11 reset done", 32'(done_o), 32'd0);
    chk("R11 reset start pointer", 32'(start_ptr_o), 32'd0);
    rd_strobe_i = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd_strobe_i = 1'b0;
    chk("R10 idle strobes ignored", 32'(done_o), 32'd0);

    run_capture(0, 8'h70, 8'h90, -1, "random");
    run_capture(1, 8'h73, 8'h93, 83, "stale/levels");
    run_capture(2, 8'h70, 8'h90, 780, "late wrap");
    abort_run(300);
    run_capture(0, 8'h71, 8'h92, -1, "after restart");
    for (int r = 0; r < 3; r++) begin
      logic [7:0] a, t;
      a = 8'(8'h20 + ($urandom % 8'hE0));
      t = 8'($urandom % 8'hE0);
      run_capture(3, a, t, -1, "random levels");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule